// File: doc/BRIEF.md
# Reconfigurable Latch / AND-OR Cell

A single logic cell whose behaviour is fixed by a static two-bit configuration code. It can act as a storage latch that is open while the clock is high, as a storage latch that is open while the clock is low, or as a purely combinational sum of two two-input products. The configuration code stands in for the one-time wiring choices that a fabric of such cells would normally make. Whatever the code, the cell's clock pin feeds the same single gating point, so the clock sees the same load in every configuration.

Every configuration drives a true output and an inverted output. A probe path lets a test bus observe the cell's output at any time, before or after the cell is configured. A high-open cell whose output drives a low-open cell on the same clock forms an edge-triggered register.

Top module: `rcl_cell`

## Requirements
- R1: With `cfg` = 0, `f` follows `d` while `clk_g` is high and holds the value `d` had at the falling edge while `clk_g` is low.
- R2: With `cfg` = 1, `f` follows `d` while `clk_g` is low and holds the value `d` had at the rising edge while `clk_g` is high.
- R3: With `cfg` = 2, `f` = (y[0] AND y[1]) OR (y[2] AND y[3]) at all times, whatever the values of `d` and `clk_g`.
- R4: `cfg` = 3 behaves exactly as `cfg` = 0.
- R5: `f_n` is always the inverse of `f`, in every configuration.
- R6: `probe_out` equals `f` while `probe_en` is 1, and is 0 while `probe_en` is 0, in every configuration.
- R7: While `rst` is 1 the stored latch value is 0, so `f` is 0 in the latch configurations; after `rst` falls during the closed phase, `f` stays 0 until the latch next opens.
- R8: A `cfg` = 0 cell whose `f` drives the `d` of a `cfg` = 1 cell on the same clock forms a register: the second cell's `f` takes the value the first cell's `d` had at the falling clock edge and holds it until the next falling edge, ignoring changes of `d` between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_g | input | 1 | Global clock, always attached to the cell's gating point |
| rst | input | 1 | Active-high clear of the stored latch value |
| cfg | input | 2 | Static configuration code: 0 high-open latch, 1 low-open latch, 2 AND-OR, 3 as 0 |
| d | input | 1 | Latch data input |
| y | input | NUM_TERMS*TERM_W (4) | Combinational product inputs, grouped TERM_W bits per product |
| probe_en | input | 1 | Enables the cell onto the probe output |
| f | output | 1 | True output |
| f_n | output | 1 | Inverted output |
| probe_out | output | 1 | Probe output toward a shared test bus |

## Verification
In the chained pair, the high-open cell closing and the low-open cell opening happen on the same falling clock edge, so capture and hand-over coincide. The bench provokes this by moving `d` to the opposite value one nanosecond after each falling edge and judging that the second cell still shows the pre-edge value in both the following low and high phases. The single-cell sweeps also switch configuration mid-phase and change data on both clock levels, to show that each latch opens and closes on the intended level only.

// File: rtl/rcl_pkg.sv
`timescale 1ns/1ps
package rcl_pkg;

    localparam int CFG_W = 2;

    typedef enum logic [CFG_W-1:0] {
        CFG_HI_LATCH = 2'd0,
        CFG_LO_LATCH = 2'd1,
        CFG_ANDOR    = 2'd2,
        CFG_SPARE    = 2'd3
    } cfg_code_e;

    typedef struct packed {
        logic open_hi;
        logic open_lo;
        logic comb;
    } cell_sel_t;

    function automatic cell_sel_t decode_cfg(input logic [CFG_W-1:0] code);
        cell_sel_t s;
        s = '0;
        unique case (code)
            CFG_LO_LATCH: s.open_lo = 1'b1;
            CFG_ANDOR:    s.comb    = 1'b1;
            default:      s.open_hi = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rcl_cfg_decode.sv
`timescale 1ns/1ps
module rcl_cfg_decode
    import rcl_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    output cell_sel_t        sel
);

    always_comb begin
        sel = decode_cfg(cfg);
    end

endmodule

// File: rtl/rcl_andor.sv
`timescale 1ns/1ps
module rcl_andor #(
    parameter int NUM_TERMS = 2,
    parameter int TERM_W    = 2
) (
    input  logic [NUM_TERMS*TERM_W-1:0] y,
    output logic                        f
);

    logic [NUM_TERMS-1:0] prod;

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        assign prod[t] = &y[t*TERM_W +: TERM_W];
    end

    assign f = |prod;

endmodule

// File: rtl/rcl_store.sv
`timescale 1ns/1ps
module rcl_store (
    input  logic clk,
    input  logic rst,
    input  logic open_hi,
    input  logic open_lo,
    input  logic d,
    output logic q
);

    logic gate;

    // The clock reaches exactly one gating point regardless of configuration.
    assign gate = (open_hi & clk) | (open_lo & ~clk);

    always_latch begin
        if (rst) begin
            q = 1'b0;
        end else if (gate) begin
            q = d;
        end
    end

    AST_HI_LATCH_CAPTURE: assert property (@(negedge clk) disable iff (rst)
        open_hi |-> (q == d)); // R1

    AST_LO_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        open_lo |-> (q == d)); // R2

endmodule

// File: rtl/rcl_probe.sv
`timescale 1ns/1ps
module rcl_probe (
    input  logic en,
    input  logic f,
    output logic p
);

    assign p = en & f;

endmodule

// File: rtl/rcl_cell.sv
`timescale 1ns/1ps
module rcl_cell
    import rcl_pkg::*;
#(
    parameter int NUM_TERMS = 2,
    parameter int TERM_W    = 2
) (
    input  logic                        clk_g,
    input  logic                        rst,
    input  logic [1:0]                  cfg,
    input  logic                        d,
    input  logic [NUM_TERMS*TERM_W-1:0] y,
    input  logic                        probe_en,
    output logic                        f,
    output logic                        f_n,
    output logic                        probe_out
);

    localparam int Y_W = NUM_TERMS * TERM_W;

    cell_sel_t sel;
    logic      q_store;
    logic      f_comb;

    rcl_cfg_decode u_dec (
        .cfg (cfg),
        .sel (sel)
    );

    rcl_store u_store (
        .clk     (clk_g),
        .rst     (rst),
        .open_hi (sel.open_hi),
        .open_lo (sel.open_lo),
        .d       (d),
        .q       (q_store)
    );

    rcl_andor #(
        .NUM_TERMS (NUM_TERMS),
        .TERM_W    (TERM_W)
    ) u_andor (
        .y (y),
        .f (f_comb)
    );

    assign f   = sel.comb ? f_comb : q_store;
    assign f_n = ~f;

    rcl_probe u_probe (
        .en (probe_en),
        .f  (f),
        .p  (probe_out)
    );

    logic [Y_W-1:0] y_seen;
    assign y_seen = y;

    AST_ANDOR_NO_CLOCK_EFFECT: assert property (@(posedge clk_g) disable iff (rst)
        (cfg == CFG_ANDOR) && $past(cfg == CFG_ANDOR) && $stable(y_seen) |-> $stable(f)); // R3

    AST_SPARE_AS_HI_LATCH: assert property (@(negedge clk_g) disable iff (rst)
        (cfg == CFG_SPARE) |-> (f == d)); // R4

    AST_COMPLEMENT_PAIR: assert property (@(posedge clk_g) disable iff (rst)
        f_n != f); // R5

    AST_PROBE_TRACKS: assert property (@(posedge clk_g) disable iff (rst)
        probe_en |-> (probe_out == f)); // R6

    AST_PROBE_QUIET: assert property (@(posedge clk_g) disable iff (rst)
        !probe_en |-> !probe_out); // R6

endmodule

// File: tb/rcl_cell_tb_top.sv
`timescale 1ns/1ps
module rcl_cell_tb_top;

    logic       clk_g = 1'b0;
    logic       rst;
    logic [1:0] cfg;
    logic       d;
    logic [3:0] y;
    logic       probe_en;
    logic       f, f_n, probe_out;
    logic       s_f, s_fn, s_p;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk_g = ~clk_g;

    rcl_cell dut_i (
        .clk_g(clk_g), .rst(rst), .cfg(cfg), .d(d), .y(y), .probe_en(probe_en),
        .f(f), .f_n(f_n), .probe_out(probe_out)
    );

    rcl_cell slv_i (
        .clk_g(clk_g), .rst(rst), .cfg(2'd1), .d(f), .y(4'h0), .probe_en(1'b1),
        .f(s_f), .f_n(s_fn), .probe_out(s_p)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // R1 / R4: high-open latch sweep
    task automatic sweep_hi(input logic [1:0] code, input string tag);
        @(posedge clk_g) #0.2 cfg = code;
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                @(posedge clk_g) #0.5 d = a[0];
                #0.5 chk({tag, " open"}, f, a[0]);
                chk("R5", f_n, ~a[0]);
                chk("R6", probe_out, a[0]);
                @(negedge clk_g) #0.5 d = b[0];
                #0.5 chk({tag, " hold"}, f, a[0]);
            end
        end
    endtask

    // R2: low-open latch sweep
    task automatic sweep_lo();
        @(negedge clk_g) #0.2 cfg = 2'd1;
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                @(negedge clk_g) #0.5 d = a[0];
                #0.5 chk("R2 open", f, a[0]);
                chk("R5", f_n, ~a[0]);
                @(posedge clk_g) #0.5 d = b[0];
                #0.5 chk("R2 hold", f, a[0]);
                chk("R6", probe_out, a[0]);
            end
        end
    endtask

    initial begin
        rst = 1'b1; cfg = 2'd0; d = 1'b1; y = 4'h0; probe_en = 1'b1;
        // R7: reset state
        repeat (2) @(posedge clk_g);
        #0.5 chk("R7 reset f", f, 1'b0);
        chk("R7 reset f_n", f_n, 1'b1);
        chk("R7 reset chain", s_f, 1'b0);
        @(negedge clk_g) #0.5 rst = 1'b0;
        #0.5 chk("R7 held after release", f, 1'b0);
        @(posedge clk_g) #0.5 chk("R1 opens after reset", f, 1'b1);

        sweep_hi(2'd0, "R1");
        sweep_lo();
        sweep_hi(2'd3, "R4");

        // R3 / R6: exhaustive product inputs, data, probe enable
        @(posedge clk_g) #0.2 cfg = 2'd2;
        #0.3;
        for (int v = 0; v < 64; v++) begin
            logic e;
            y = v[3:0]; d = v[4]; probe_en = v[5];
            e = (v[0] & v[1]) | (v[2] & v[3]);
            #1 chk("R3", f, e);
            chk("R5", f_n, ~e);
            chk("R6", probe_out, v[5] & e);
        end
        probe_en = 1'b1;

        // R8: chained high-open then low-open forms a falling-edge register
        @(posedge clk_g) #0.2 cfg = 2'd0;
        for (int i = 0; i < 12; i++) begin
            logic p;
            p = ((12'b1011_0010_0111 >> i) & 1) != 0;
            @(posedge clk_g) #1 d = p;
            @(negedge clk_g) #1 d = ~p;
            #0.5 chk("R8 low phase", s_f, p);
            @(posedge clk_g) #0.5 chk("R8 high phase", s_f, p);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule